// File: doc/BRIEF.md
# Trap and Slot-Fault Exception Entry Sequencer

This block steers a processor core into an exception handler for one of two causes. The first is a software trap, which carries its vector number in the instruction. The second is a forbidden instruction found in the delay slot of a delayed branch. The delay-slot word is classified in the cycle it is decoded, and a forbidden word starts the sequence at once. A trap takes its vector from the instruction. A slot fault uses a fixed vector number set by a parameter.

Once started, the sequencer reads the handler address from the vector table at `vbr + 4*vector`. It then pushes the status register and the program counter onto a downward-growing stack, one memory write each. Each memory access waits for its own ready handshake. Last, it pulses a PC-load strobe that carries the handler address and the updated stack pointer to the fetch unit. The jump is not delayed.

The PC that is saved depends on the cause. A trap saves the address of the instruction that follows it. A slot fault saves the target of the delayed branch. `busy` is high for the whole sequence, and the core stalls on it.

Top module: `trap_slot_exc_seq`

## Requirements
- R1: For a trap, the single vector-table read goes to address `vbr + 4*trap_vec`. The returned word becomes `pc_new`.
- R2: For a slot fault, the vector-table read goes to `vbr + 4*SLOT_VEC`, with SLOT_VEC defaulting to 6.
- R3: Accesses always come in this order: one read, then a write of the status register, then a write of the PC, then a one-cycle `pc_load`. No other access occurs between them.
- R4: The status register is written to `sp_in-4` and the PC to `sp_in-8`. `sp_new` equals `sp_in-8` while `pc_load` is high.
- R5: For a trap, the pushed PC equals `trap_next_pc`.
- R6: For a slot fault, the pushed PC equals `slot_target`.
- R7: A valid delay-slot word is forbidden whatever the FPU state when any of these holds:
  - bits [15:12] are 0xA (undefined), 0xB (divide), 0xC (bank restore), 0xD (32-bit form) or 0xE (writes the PC);
  - the word is 0xFFFF.
- R8: Words with bits [15:12] equal to 0x9 (FPU-related CPU operation) or 0xF (floating-point operation) are forbidden only while `fpu_standby` is 1. All other words start nothing.
- R9: `busy` is high in the cycle after a forbidden word is presented with `slot_valid`. It is also high in the cycle after `trap_req`.
- R10: A memory request, together with its address and data, stays steady until its ready input is seen high.
- R11: A trap or slot fault presented while `busy` is high is ignored. It causes no access and no later sequence.
- R12: `pc_load` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R13: A forbidden slot word and a trap in the same cycle are handled as a slot fault.
- R14: After reset, `busy`, `mem_rd_req`, `mem_wr_req` and `pc_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Trap instruction decoded |
| trap_vec | input | VEC_W | Vector number from the trap instruction |
| trap_next_pc | input | ADDR_W | Address of the instruction after the trap |
| slot_valid | input | 1 | Delay-slot word being decoded |
| slot_insn | input | INSN_W | Delay-slot instruction word |
| slot_target | input | ADDR_W | Target of the delayed branch |
| fpu_standby | input | 1 | FPU is in module standby |
| vbr | input | ADDR_W | Vector table base |
| sp_in | input | ADDR_W | Stack pointer at detection |
| sr_in | input | ADDR_W | Status register at detection |
| mem_rd_req | output | 1 | Vector read request |
| mem_rd_addr | output | ADDR_W | Vector read address |
| mem_rd_data | input | ADDR_W | Read data |
| mem_rd_ready | input | 1 | Read completes this cycle |
| mem_wr_req | output | 1 | Stack write request |
| mem_wr_addr | output | ADDR_W | Stack write address |
| mem_wr_data | output | ADDR_W | Stack write data |
| mem_wr_ready | input | 1 | Write completes this cycle |
| busy | output | 1 | Sequence in progress; stall the core |
| pc_load | output | 1 | One-cycle strobe to load the new PC |
| pc_new | output | ADDR_W | Handler address |
| sp_new | output | ADDR_W | Stack pointer after both pushes |

## Verification
The bench goes after four kinds of error. The first is the choice of saved PC. A design that swapped the two causes would push the trap's next address on a slot fault, or the reverse. The second is the FPU-standby gating of the 0x9 and 0xF groups and the all-ones word: a wrong classifier either traps on legal FPU code or lets a forbidden word through silently. The third is a trap or fault that arrives mid-sequence. A design that did not ignore it would run a second sequence or corrupt the stack pointer in the middle of the pushes. The fourth is ready delays on the memory ports, including ready on the first cycle of a request. A design that advanced without ready, or released the request one cycle early, would skip or repeat an access and push to the wrong address.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_VEC,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_JUMP
  } seq_state_e;

  // Opcode group codes in bits [15:12] of the delay-slot word
  localparam logic [3:0] GRP_FPU_CPU  = 4'h9;
  localparam logic [3:0] GRP_UNDEF    = 4'hA;
  localparam logic [3:0] GRP_DIVIDE   = 4'hB;
  localparam logic [3:0] GRP_BANK_RST = 4'hC;
  localparam logic [3:0] GRP_LONG     = 4'hD;
  localparam logic [3:0] GRP_PC_WRITE = 4'hE;
  localparam logic [3:0] GRP_FPU_OP   = 4'hF;

  function automatic logic group_forbidden(input logic [3:0] grp, input logic fpu_sb);
    logic r;
    case (grp)
      GRP_UNDEF, GRP_DIVIDE, GRP_BANK_RST, GRP_LONG, GRP_PC_WRITE: r = 1'b1;
      GRP_FPU_CPU, GRP_FPU_OP:                                     r = fpu_sb;
      default:                                                     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/exc_slot_classifier.sv
module exc_slot_classifier #(
  parameter int INSN_W = 16
) (
  input  logic              slot_valid,
  input  logic [INSN_W-1:0] slot_insn,
  input  logic              fpu_standby,
  output logic              slot_fault
);
  import exc_seq_pkg::*;

  localparam int GRP_MSB = INSN_W - 1;
  localparam int GRP_LSB = INSN_W - 4;

  logic [3:0] grp;
  logic       all_ones;
  logic       forbidden;

  assign grp       = slot_insn[GRP_MSB:GRP_LSB];
  assign all_ones  = &slot_insn;
  assign forbidden = group_forbidden(grp, fpu_standby) | all_ones;
  assign slot_fault = slot_valid & forbidden;

endmodule

// File: rtl/exc_cause_capture.sv
module exc_cause_capture #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8,
  parameter logic [VEC_W-1:0] SLOT_VEC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              take_slot,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic [ADDR_W-1:0] trap_next_pc,
  input  logic [ADDR_W-1:0] slot_target,
  input  logic [ADDR_W-1:0] vbr,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] sr_in,
  input  logic              sp_dec,
  output logic [ADDR_W-1:0] entry_addr_q,
  output logic [ADDR_W-1:0] saved_pc_q,
  output logic [ADDR_W-1:0] saved_sr_q,
  output logic [ADDR_W-1:0] sp_q
);
  localparam int WORD_BYTES = 4;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [VEC_W-1:0] vec);
    return base + ADDR_W'({vec, 2'b00});
  endfunction

  function automatic logic [ADDR_W-1:0] sp_after_push(input logic [ADDR_W-1:0] sp);
    return sp - ADDR_W'(WORD_BYTES);
  endfunction

  logic [VEC_W-1:0] vec_sel;
  assign vec_sel = take_slot ? SLOT_VEC : trap_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_addr_q <= '0;
      saved_pc_q   <= '0;
      saved_sr_q   <= '0;
      sp_q         <= '0;
    end else if (capture) begin
      entry_addr_q <= entry_addr(vbr, vec_sel);
      saved_pc_q   <= take_slot ? slot_target : trap_next_pc;
      saved_sr_q   <= sr_in;
      sp_q         <= sp_in;
    end else if (sp_dec) begin
      sp_q <= sp_after_push(sp_q);
    end
  end

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_data,
  input  logic              wr_ready,
  output exc_seq_pkg::seq_state_e state_q,
  output logic              rd_req,
  output logic              wr_req,
  output logic              wr_sel_pc,
  output logic              sp_dec,
  output logic              jump,
  output logic [ADDR_W-1:0] handler_q
);
  import exc_seq_pkg::*;

  seq_state_e state_d;

  assign rd_req    = (state_q == ST_FETCH_VEC);
  assign wr_req    = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC);
  assign wr_sel_pc = (state_q == ST_PUSH_PC);
  assign sp_dec    = wr_req & wr_ready;
  assign jump      = (state_q == ST_JUMP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (start)    state_d = ST_FETCH_VEC;
      ST_FETCH_VEC: if (rd_ready) state_d = ST_PUSH_SR;
      ST_PUSH_SR:   if (wr_ready) state_d = ST_PUSH_PC;
      ST_PUSH_PC:   if (wr_ready) state_d = ST_JUMP;
      ST_JUMP:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      handler_q <= '0;
    end else begin
      state_q <= state_d;
      if (rd_req && rd_ready) handler_q <= rd_data;
    end
  end

endmodule

// File: rtl/trap_slot_exc_seq.sv
module trap_slot_exc_seq #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8,
  parameter int INSN_W = 16,
  parameter logic [VEC_W-1:0] SLOT_VEC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic [ADDR_W-1:0] trap_next_pc,
  input  logic              slot_valid,
  input  logic [INSN_W-1:0] slot_insn,
  input  logic [ADDR_W-1:0] slot_target,
  input  logic              fpu_standby,
  input  logic [ADDR_W-1:0] vbr,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] sr_in,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              mem_rd_ready,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [ADDR_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready,
  output logic              busy,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_new,
  output logic [ADDR_W-1:0] sp_new
);
  import exc_seq_pkg::*;

  localparam int WORD_BYTES = 4;

  // Named internal events, used by the bound checker
  logic       ev_slot_fault;
  logic       ev_start;
  logic       ev_take_slot;
  logic       ev_sp_dec;
  logic       ev_wr_pc;
  seq_state_e state_q;

  logic [ADDR_W-1:0] entry_addr_q, saved_pc_q, saved_sr_q, sp_q, handler_q;

  exc_slot_classifier #(.INSN_W(INSN_W)) u_classify (
    .slot_valid (slot_valid),
    .slot_insn  (slot_insn),
    .fpu_standby(fpu_standby),
    .slot_fault (ev_slot_fault)
  );

  assign busy         = (state_q != ST_IDLE);
  assign ev_start     = !busy && (trap_req || ev_slot_fault);
  assign ev_take_slot = ev_slot_fault;

  exc_cause_capture #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .SLOT_VEC(SLOT_VEC)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (ev_start),
    .take_slot   (ev_take_slot),
    .trap_vec    (trap_vec),
    .trap_next_pc(trap_next_pc),
    .slot_target (slot_target),
    .vbr         (vbr),
    .sp_in       (sp_in),
    .sr_in       (sr_in),
    .sp_dec      (ev_sp_dec),
    .entry_addr_q(entry_addr_q),
    .saved_pc_q  (saved_pc_q),
    .saved_sr_q  (saved_sr_q),
    .sp_q        (sp_q)
  );

  exc_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev_start),
    .rd_ready (mem_rd_ready),
    .rd_data  (mem_rd_data),
    .wr_ready (mem_wr_ready),
    .state_q  (state_q),
    .rd_req   (mem_rd_req),
    .wr_req   (mem_wr_req),
    .wr_sel_pc(ev_wr_pc),
    .sp_dec   (ev_sp_dec),
    .jump     (pc_load),
    .handler_q(handler_q)
  );

  assign mem_rd_addr = entry_addr_q;
  assign mem_wr_addr = sp_q - ADDR_W'(WORD_BYTES);
  assign mem_wr_data = ev_wr_pc ? saved_pc_q : saved_sr_q;
  assign pc_new      = handler_q;
  assign sp_new      = sp_q;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ev_start,
  input logic              ev_slot_fault,
  input logic              ev_wr_pc,
  input logic              mem_rd_req,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_req,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [ADDR_W-1:0] mem_wr_data,
  input logic              pc_load
);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ev_start |=> busy); // R9
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ready |=> mem_rd_req && $stable(mem_rd_addr)); // R10
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ready |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R10
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd_req, mem_wr_req, pc_load}) <= 1); // R3
  AST_READ_THEN_SR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_ready |=> mem_wr_req && !ev_wr_pc); // R3
  AST_SR_THEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !ev_wr_pc && mem_wr_ready |=> mem_wr_req && ev_wr_pc); // R3
  AST_PC_PUSH_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !ev_wr_pc && mem_wr_ready |=> mem_wr_addr == $past(mem_wr_addr) - 4); // R4
  AST_LOAD_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && ev_wr_pc && mem_wr_ready |=> pc_load); // R3
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load && !busy); // R12
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_start); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_req && !mem_wr_req && !pc_load); // R14
  AST_FAULT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slot_fault && !busy |-> ev_start); // R7

endmodule

bind trap_slot_exc_seq exc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .ev_start     (ev_start),
  .ev_slot_fault(ev_slot_fault),
  .ev_wr_pc     (ev_wr_pc),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .mem_wr_req   (mem_wr_req),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .pc_load      (pc_load)
);

// File: tb/trap_slot_exc_seq_tb.sv
module trap_slot_exc_seq_tb_top;
  localparam logic [7:0] SLOT_VEC_EXP = 8'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0;
  logic [7:0]  trap_vec = '0;
  logic [31:0] trap_next_pc = '0;
  logic        slot_valid = 1'b0;
  logic [15:0] slot_insn = '0;
  logic [31:0] slot_target = '0;
  logic        fpu_standby = 1'b0;
  logic [31:0] vbr = '0, sp_in = '0, sr_in = '0;
  logic        mem_rd_req, mem_wr_req, busy, pc_load;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data, pc_new, sp_new;
  logic [31:0] mem_rd_data = '0;
  logic        mem_rd_ready = 1'b0, mem_wr_ready = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;
  int max_delay = 0;
  int rd_wait = 0, wr_wait = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] rd_addr_log;
  logic [31:0] wr_addr_log [0:3];
  logic [31:0] wr_data_log [0:3];

  always #2 clk = ~clk;

  trap_slot_exc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_vec(trap_vec),
    .trap_next_pc(trap_next_pc), .slot_valid(slot_valid), .slot_insn(slot_insn),
    .slot_target(slot_target), .fpu_standby(fpu_standby), .vbr(vbr), .sp_in(sp_in),
    .sr_in(sr_in), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_ready(mem_rd_ready), .mem_wr_req(mem_wr_req),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready),
    .busy(busy), .pc_load(pc_load), .pc_new(pc_new), .sp_new(sp_new));

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic bit expect_forbidden(input logic [15:0] w, input bit sb);
    if (w == 16'hFFFF) return 1;
    if (w[15:12] >= 4'hA && w[15:12] <= 4'hE) return 1;
    if (w[15:12] == 4'h9 || w[15:12] == 4'hF) return sb;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: ready after a random delay, logs each completed access
  always @(negedge clk) begin
    if (mem_rd_ready) mem_rd_ready = 1'b0;
    else if (mem_rd_req) begin
      if (rd_wait == 0) begin
        mem_rd_ready = 1'b1;
        mem_rd_data = table_word(mem_rd_addr);
        rd_addr_log = mem_rd_addr;
        n_rd++;
        rd_wait = (max_delay == 0) ? 0 : int'($urandom_range(max_delay, 0));
      end else rd_wait--;
    end
    if (mem_wr_ready) mem_wr_ready = 1'b0;
    else if (mem_wr_req) begin
      if (wr_wait == 0) begin
        mem_wr_ready = 1'b1;
        if (n_wr < 4) begin
          wr_addr_log[n_wr] = mem_wr_addr;
          wr_data_log[n_wr] = mem_wr_data;
        end
        n_wr++;
        wr_wait = (max_delay == 0) ? 0 : int'($urandom_range(max_delay, 0));
      end else wr_wait--;
    end
  end

  task automatic run_seq(input bit use_trap, input bit use_slot, input logic [15:0] insn,
                         input bit sb, input logic [7:0] vec, input logic [31:0] npc,
                         input logic [31:0] tgt, input logic [31:0] base,
                         input logic [31:0] sp, input logic [31:0] sr, input bit poke_busy);
    logic [7:0] evec;
    logic [31:0] epc;
    bit is_slot;
    int waited;
    is_slot = use_slot && expect_forbidden(insn, sb);
    evec = is_slot ? SLOT_VEC_EXP : vec;
    epc  = is_slot ? tgt : npc;
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    trap_req = use_trap; trap_vec = vec; trap_next_pc = npc;
    slot_valid = use_slot; slot_insn = insn; fpu_standby = sb;
    slot_target = tgt; vbr = base; sp_in = sp; sr_in = sr;
    @(negedge clk);
    trap_req = 1'b0; slot_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after detection", 32'(busy), 32'd1);
    if (poke_busy) begin
      trap_req = 1'b1; trap_vec = vec ^ 8'h3C; slot_valid = 1'b1; slot_insn = 16'hA000;
      sp_in = sp + 32'h100;
      @(negedge clk);
      trap_req = 1'b0; slot_valid = 1'b0;
    end
    waited = 0;
    while (!pc_load && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(pc_load == 1'b1, "R3 pc_load reached", 32'(pc_load), 32'd1);
    chk(n_rd == 1 && n_wr == 2, "R3 access counts rd*16+wr", 32'(n_rd * 16 + n_wr), 32'h12);
    chk(rd_addr_log == base + {22'd0, evec, 2'b00}, is_slot ? "R2 slot vector addr" : "R1 trap vector addr",
        rd_addr_log, base + {22'd0, evec, 2'b00});
    chk(pc_new == table_word(base + {22'd0, evec, 2'b00}), "R1 handler pc", pc_new,
        table_word(base + {22'd0, evec, 2'b00}));
    chk(wr_addr_log[0] == sp - 4 && wr_data_log[0] == sr, "R4 sr push addr", wr_addr_log[0], sp - 4);
    chk(wr_addr_log[1] == sp - 8, "R4 pc push addr", wr_addr_log[1], sp - 8);
    chk(wr_data_log[1] == epc, is_slot ? "R6 saved pc (slot)" : "R5 saved pc (trap)", wr_data_log[1], epc);
    chk(sp_new == sp - 8, "R4 sp_new", sp_new, sp - 8);
    @(negedge clk);
    chk(!pc_load && !busy, "R12 single pulse then idle", {30'd0, pc_load, busy}, 32'd0);
    repeat (4) @(negedge clk);
    chk(!busy && n_rd == 1 && n_wr == 2, "R11 no follow-on sequence", 32'(busy), 32'd0);
  endtask

  task automatic check_legal(input logic [15:0] insn, input bit sb);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    slot_valid = 1'b1; slot_insn = insn; fpu_standby = sb;
    @(negedge clk);
    slot_valid = 1'b0;
    chk(!busy, "R8 legal word starts nothing", {insn, 16'(busy)}, {insn, 16'd0});
    repeat (3) @(negedge clk);
    chk(!busy && n_rd == 0, "R8 no access for legal word", 32'(n_rd), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd_req && !mem_wr_req && !pc_load, "R14 reset state",
        {28'd0, busy, mem_rd_req, mem_wr_req, pc_load}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed: trap, zero delay
    run_seq(1, 0, 16'h0000, 0, 8'h21, 32'h0000_1002, 32'h0, 32'h0000_4000, 32'h2000_0100, 32'h0000_00F0, 0);
    // R13: trap and forbidden slot word together
    run_seq(1, 1, 16'hE123, 0, 8'h40, 32'h0000_2222, 32'h0000_8888, 32'h0001_0000, 32'h2000_0200, 32'h1, 0);
    // R11: requests while busy, with delays
    max_delay = 3;
    run_seq(1, 0, 16'h0, 0, 8'hFF, 32'hABCD_0000, 32'h0, 32'hFFFF_FC00, 32'h0000_0008, 32'h3, 1);
    // R7: each always-forbidden group and the all-ones word
    for (int g = 10; g <= 14; g++)
      run_seq(0, 1, {4'(g), 12'h5A5}, 0, 8'h0, 32'h0, 32'h0000_3000 + 32'(g), 32'h0000_0400, 32'h1000_0000, 32'(g), 0);
    run_seq(0, 1, 16'hFFFF, 0, 8'h0, 32'h0, 32'h0000_7770, 32'h0000_0000, 32'h1000_0040, 32'h5, 0);
    // R8: FPU groups under standby, legal words otherwise
    run_seq(0, 1, 16'h9012, 1, 8'h0, 32'h0, 32'h0000_9990, 32'h0000_0800, 32'h1000_0080, 32'h6, 0);
    run_seq(0, 1, 16'hF00C, 1, 8'h0, 32'h0, 32'h0000_AAA0, 32'h0000_0800, 32'h1000_00C0, 32'h7, 0);
    check_legal(16'h9012, 0);
    check_legal(16'hF00C, 0);
    check_legal(16'h0000, 1);
    check_legal(16'h8FFF, 1);
    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [15:0] w;
      bit sb, tr;
      w  = 16'($urandom);
      sb = 1'($urandom);
      tr = 1'($urandom);
      if (!tr && !expect_forbidden(w, sb)) check_legal(w, sb);
      else run_seq(tr, !tr || 1'($urandom), w, sb, 8'($urandom), $urandom, $urandom,
                   $urandom & 32'hFFFF_F000, $urandom | 32'h10, $urandom, 1'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule